// File: doc/BRIEF.md
# SMM Window and Legacy Hole Decoder

This block decides, for every memory request, whether the request is served by DRAM or forwarded to the I/O path. It holds two small configuration dwords: one carries a legacy hole enable, the other controls a protected 128 KB window used by system-management mode (SMM) code. A configuration port writes and reads those dwords. Each request carries its address, a flag that says whether SMM decode is active, and a flag that marks it as a code fetch rather than a data reference.

The window is fixed at A0000h to BFFFFh. Whether it is visible depends on the SMM flag, on the global enable, and on two override bits. The "open" bit exposes the window outside SMM so that firmware can fill it. The "closed" bit hides it from data references while code fetches still reach it. A sticky lock bit freezes the enable and the open bit and forces the open bit low, so the window cannot be exposed again until reset.

The route decision is combinational from the request and the current register state. A configuration write is captured on the clock edge and affects requests from the following cycle.

Top module: `smm_window_decoder`

## Requirements
- R1: After reset the dword at offset 48h reads 0000_0000h and the dword at offset 4Ch reads 0000_0200h.
- R2: Bit 7 of offset 48h is the hole enable. While it is 1, addresses 00F0_0000h to 00FF_FFFFh give routeDram = 0. While it is 0, those addresses give routeDram = 1.
- R3: Addresses outside the window and outside an enabled hole always give routeDram = 1, whatever the SMM and code flags are.
- R4: Bit 12 of offset 4Ch is the lock. Writing 1 sets it. Writing 0 does not clear it. Only reset clears it.
- R5: Once the lock is set, the open bit (bit 14) reads 0. Later writes to the open, lock and global-enable (bit 11) bits are ignored, while the closed bit (bit 13) stays writable.
- R6: Bits 10:8 of offset 4Ch always read 010, and write data for them is discarded. All other unimplemented bits of both dwords read 0. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R7: With the global enable at 1, a window address (000A_0000h to 000B_FFFFh) from an SMM request gives routeDram = 1. With the global enable and the open bit both at 0, every window request gives routeDram = 0.
- R8: With the closed bit at 1, SMM data references to the window give routeDram = 0. SMM code fetches to the window still give routeDram = 1 when the global enable is 1.
- R9: With the open bit at 1 and the lock at 0, window requests give routeDram = 1 whether or not SMM is active and regardless of the global enable. The one exception is an SMM data reference while the closed bit is 1, which gives routeDram = 0.
- R10: routeDram follows the request inputs in the same cycle. A configuration write affects requests only from the cycle after the write is presented. Register contents do not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe for the dword at cfgAddr |
| cfgAddr | input | 8 | Configuration dword offset for reads and writes |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Combinational read data of the dword at cfgAddr |
| reqAddr | input | 32 | Memory request address |
| reqSmm | input | 1 | SMM decode active for this request |
| reqCode | input | 1 | 1 for a code fetch, 0 for a data reference |
| routeDram | output | 1 | 1 routes the request to DRAM, 0 forwards it to the I/O path |

## Verification
Both routeDram and cfgRdData are due in the same cycle their inputs are presented, because neither passes through a register. A configuration write becomes visible one clock edge later. The bench drives every stimulus just after a rising edge and pushes the expected value into a scoreboard queue. A monitor compares at the next falling edge, so each comparison lands inside the cycle its result belongs to. To confirm that a write does not act early, one request is driven in the same cycle as a write and is expected to see the old settings, and an identical request one cycle later is expected to see the new ones.

// File: rtl/smmwin_pkg.sv
package smmwin_pkg;

  localparam int CFG_AW = 8;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] OFS_HOLE  = 8'h48;
  localparam logic [CFG_AW-1:0] OFS_SMRAM = 8'h4C;

  localparam int BIT_HOLE   = 7;
  localparam int BIT_OPEN   = 14;
  localparam int BIT_CLOSED = 13;
  localparam int BIT_LOCK   = 12;
  localparam int BIT_GEN    = 11;
  localparam int SEG_LO     = 8;
  localparam int SEG_HI     = 10;

  localparam logic [SEG_HI-SEG_LO:0] SEG_VALUE = 3'b010;

  // Writable bits of each dword; everything else is discarded on write.
  localparam logic [CFG_DW-1:0] HOLE_WR_MASK  = CFG_DW'(1) << BIT_HOLE;
  localparam logic [CFG_DW-1:0] SMRAM_WR_MASK = (CFG_DW'(1) << BIT_OPEN)
                                              | (CFG_DW'(1) << BIT_CLOSED)
                                              | (CFG_DW'(1) << BIT_LOCK)
                                              | (CFG_DW'(1) << BIT_GEN);

  // Strobes from the control decoder into the register datapath.
  typedef struct packed {
    logic holeWr;
    logic smramWr;
    logic holeVal;
    logic openVal;
    logic closedVal;
    logic lockSet;
    logic genVal;
  } cfgStrobe_t;

  // Architectural register state.
  typedef struct packed {
    logic holeEn;
    logic openBit;
    logic closedBit;
    logic lockBit;
    logic genBit;
  } cfgState_t;

endpackage

// File: rtl/smmwin_range.sv
module smmwin_range #(
  parameter int               ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] SIZE  = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  // One extra bit so that a range ending at the top of the space cannot wrap.
  localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

  logic [ADDR_W:0] addrExt;

  always_comb begin
    addrExt = {1'b0, addr};
    hit     = (addrExt >= {1'b0, BASE}) && (addrExt < LIMIT);
  end

endmodule

// File: rtl/smmwin_ctrl.sv
module smmwin_ctrl
  import smmwin_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgWrData,
  output cfgStrobe_t        strobe
);

  logic [CFG_DW-1:0] holeData;
  logic [CFG_DW-1:0] smramData;

  always_comb begin
    // Read-only and unimplemented bits are masked away before decoding.
    holeData  = cfgWrData & HOLE_WR_MASK;
    smramData = cfgWrData & SMRAM_WR_MASK;

    strobe           = '0;
    strobe.holeWr    = cfgWrEn && (cfgAddr == OFS_HOLE);
    strobe.smramWr   = cfgWrEn && (cfgAddr == OFS_SMRAM);
    strobe.holeVal   = holeData[BIT_HOLE];
    strobe.openVal   = smramData[BIT_OPEN];
    strobe.closedVal = smramData[BIT_CLOSED];
    strobe.lockSet   = smramData[BIT_LOCK];
    strobe.genVal    = smramData[BIT_GEN];
  end

endmodule

// File: rtl/smmwin_datapath.sv
module smmwin_datapath
  import smmwin_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_AW-1:0] cfgAddr,
  output logic [CFG_DW-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              reqCode,
  output logic              routeDram,
  output cfgState_t         state
);

  cfgState_t stateQ;
  logic      holeHit;
  logic      winHit;
  logic      smmGrant;
  logic      openGrant;
  logic      dataBlocked;

  // Register update: the lock freezes open, lock and enable; closed stays writable.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
    end else begin
      if (strobe.holeWr) begin
        stateQ.holeEn <= strobe.holeVal;
      end
      if (strobe.smramWr) begin
        stateQ.closedBit <= strobe.closedVal;
        if (!stateQ.lockBit) begin
          stateQ.genBit <= strobe.genVal;
          if (strobe.lockSet) begin
            stateQ.lockBit <= 1'b1;
            stateQ.openBit <= 1'b0;
          end else begin
            stateQ.openBit <= strobe.openVal;
          end
        end
      end
    end
  end

  assign state = stateQ;

  smmwin_range #(.ADDR_W(ADDR_W), .BASE(HOLE_BASE), .SIZE(HOLE_SIZE)) uHoleRange (
    .addr (reqAddr),
    .hit  (holeHit)
  );

  smmwin_range #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .SIZE(WIN_SIZE)) uWinRange (
    .addr (reqAddr),
    .hit  (winHit)
  );

  // Window visibility: closed hides SMM data references from both grants.
  always_comb begin
    dataBlocked = reqSmm && !reqCode && stateQ.closedBit;
    smmGrant    = reqSmm && stateQ.genBit && !dataBlocked;
    openGrant   = stateQ.openBit && !stateQ.lockBit && !dataBlocked;
    if (stateQ.holeEn && holeHit) begin
      routeDram = 1'b0;
    end else if (winHit) begin
      routeDram = smmGrant || openGrant;
    end else begin
      routeDram = 1'b1;
    end
  end

  // Configuration read mux.
  always_comb begin
    cfgRdData = '0;
    case (cfgAddr)
      OFS_HOLE: begin
        cfgRdData[BIT_HOLE] = stateQ.holeEn;
      end
      OFS_SMRAM: begin
        cfgRdData[BIT_OPEN]      = stateQ.openBit;
        cfgRdData[BIT_CLOSED]    = stateQ.closedBit;
        cfgRdData[BIT_LOCK]      = stateQ.lockBit;
        cfgRdData[BIT_GEN]       = stateQ.genBit;
        cfgRdData[SEG_HI:SEG_LO] = SEG_VALUE;
      end
      default: begin
        cfgRdData = '0;
      end
    endcase
  end

endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
  import smmwin_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgWrData,
  output logic [CFG_DW-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              reqCode,
  output logic              routeDram
);

  cfgStrobe_t strobe;
  cfgState_t  state;

  logic stHole;
  logic stOpen;
  logic stClosed;
  logic stLock;
  logic stGen;

  smmwin_ctrl uCtrl (
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .strobe    (strobe)
  );

  smmwin_datapath #(
    .ADDR_W    (ADDR_W),
    .HOLE_BASE (HOLE_BASE),
    .HOLE_SIZE (HOLE_SIZE),
    .WIN_BASE  (WIN_BASE),
    .WIN_SIZE  (WIN_SIZE)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgAddr   (cfgAddr),
    .cfgRdData (cfgRdData),
    .reqAddr   (reqAddr),
    .reqSmm    (reqSmm),
    .reqCode   (reqCode),
    .routeDram (routeDram),
    .state     (state)
  );

  assign stHole   = state.holeEn;
  assign stOpen   = state.openBit;
  assign stClosed = state.closedBit;
  assign stLock   = state.lockBit;
  assign stGen    = state.genBit;

endmodule

// File: rtl/smmwin_checker.sv
module smmwin_checker
  import smmwin_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 32'h00F0_0000,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic [CFG_DW-1:0] cfgRdData,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqSmm,
  input logic              reqCode,
  input logic              routeDram,
  input logic              stHole,
  input logic              stOpen,
  input logic              stClosed,
  input logic              stLock,
  input logic              stGen
);

  localparam logic [ADDR_W:0] HOLE_END = {1'b0, HOLE_BASE} + {1'b0, HOLE_SIZE};
  localparam logic [ADDR_W:0] WIN_END  = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic inHole;
  logic inWin;

  assign inHole = ({1'b0, reqAddr} >= {1'b0, HOLE_BASE}) && ({1'b0, reqAddr} < HOLE_END);
  assign inWin  = ({1'b0, reqAddr} >= {1'b0, WIN_BASE})  && ({1'b0, reqAddr} < WIN_END);

  AST_HOLE_FORWARDS: assert property (@(posedge clk) disable iff (!rstN)
    (stHole && inHole) |-> !routeDram); // R2

  AST_OUTSIDE_TO_DRAM: assert property (@(posedge clk) disable iff (!rstN)
    (!inHole && !inWin) |-> routeDram); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stLock |=> stLock); // R4

  AST_LOCK_OPEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    stLock |-> !stOpen); // R5

  AST_LOCK_FREEZES_GEN: assert property (@(posedge clk) disable iff (!rstN)
    stLock |=> $stable(stGen)); // R5

  AST_BASE_SEG_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == OFS_SMRAM) |-> (cfgRdData[SEG_HI:SEG_LO] == SEG_VALUE)); // R6

  AST_CLOSED_DATA_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && reqSmm && !reqCode && stClosed) |-> !routeDram); // R8

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable({stHole, stOpen, stClosed, stLock, stGen})); // R10

endmodule

bind smm_window_decoder smmwin_checker #(
  .ADDR_W    (ADDR_W),
  .HOLE_BASE (HOLE_BASE),
  .HOLE_SIZE (HOLE_SIZE),
  .WIN_BASE  (WIN_BASE),
  .WIN_SIZE  (WIN_SIZE)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .cfgRdData (cfgRdData),
  .reqAddr   (reqAddr),
  .reqSmm    (reqSmm),
  .reqCode   (reqCode),
  .routeDram (routeDram),
  .stHole    (stHole),
  .stOpen    (stOpen),
  .stClosed  (stClosed),
  .stLock    (stLock),
  .stGen     (stGen)
);

// File: tb/sim_smm_window_decoder.sv
module sim_smm_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] B_OPEN   = 32'h0000_4000;
  localparam logic [31:0] B_CLOSED = 32'h0000_2000;
  localparam logic [31:0] B_LOCK   = 32'h0000_1000;
  localparam logic [31:0] B_GEN    = 32'h0000_0800;
  localparam logic [31:0] B_HOLE   = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [31:0] reqAddr = '0;
  logic        reqSmm = 1'b0;
  logic        reqCode = 1'b0;
  logic        routeDram;

  typedef struct {
    bit          isRead;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    nRun  = 0;
  int    nFail = 0;
  bit    done  = 1'b0;

  // Reference model of the registers, kept from the requirements.
  bit mHole, mOpen, mClosed, mLock, mGen;

  smm_window_decoder u0 (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .reqAddr   (reqAddr),
    .reqSmm    (reqSmm),
    .reqCode   (reqCode),
    .routeDram (routeDram)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 8'h48) v = mHole ? B_HOLE : 32'h0;
    else if (a == 8'h4C) v = (mOpen ? B_OPEN : 0) | (mClosed ? B_CLOSED : 0)
                           | (mLock ? B_LOCK : 0) | (mGen ? B_GEN : 0) | 32'h0000_0200;
    return v;
  endfunction

  function automatic logic [31:0] expRoute(input logic [31:0] a, input bit smm, input bit code);
    bit blocked;
    blocked = smm && !code && mClosed;
    if (mHole && a >= 32'h00F0_0000 && a <= 32'h00FF_FFFF) return 32'd0;
    if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF)
      return {31'd0, (smm && mGen && !blocked) || (mOpen && !mLock && !blocked)};
    return 32'd1;
  endfunction

  function automatic void modelWrite(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h48) mHole = d[7];
    else if (a == 8'h4C) begin
      mClosed = d[13];
      if (!mLock) begin
        mGen = d[11];
        if (d[12]) begin mLock = 1; mOpen = 0; end
        else mOpen = d[14];
      end
    end
  endfunction

  function automatic void modelReset();
    mHole = 0; mOpen = 0; mClosed = 0; mLock = 0; mGen = 0;
  endfunction

  // Monitor: compare at the falling edge of the cycle the stimulus was driven in.
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (sbq.size() > 0) begin
      it  = sbq.pop_front();
      act = it.isRead ? cfgRdData : {31'd0, routeDram};
      nRun++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // Driver tasks: entered just after a rising edge, leave just after the next one.
  task automatic stepCycle();
    @(posedge clk);
    #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    modelWrite(a, d);
    stepCycle();
  endtask

  task automatic cfgRead(input logic [7:0] a, input string tag);
    item_t it;
    cfgAddr = a;
    it.isRead = 1; it.exp = expRead(a); it.tag = tag;
    sbq.push_back(it);
    stepCycle();
  endtask

  task automatic sendReq(input logic [31:0] a, input bit smm, input bit code, input string tag);
    item_t it;
    reqAddr = a; reqSmm = smm; reqCode = code;
    it.isRead = 0; it.exp = expRoute(a, smm, code); it.tag = tag;
    sbq.push_back(it);
    stepCycle();
  endtask

  // Request driven in the same cycle as a write: must see the old settings.
  task automatic writeWithReq(input logic [7:0] wa, input logic [31:0] wd,
                              input logic [31:0] a, input bit smm, input bit code,
                              input string tag);
    item_t it;
    reqAddr = a; reqSmm = smm; reqCode = code;
    it.isRead = 0; it.exp = expRoute(a, smm, code); it.tag = tag;
    sbq.push_back(it);
    cfgWrEn = 1'b1; cfgAddr = wa; cfgWrData = wd;
    modelWrite(wa, wd);
    stepCycle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R1 reset values
    cfgRead(8'h48, "R1 hole dword after reset");
    cfgRead(8'h4C, "R1 smram dword after reset");

    // R3 plain addresses go to DRAM
    sendReq(32'h0000_0000, 0, 0, "R3 low address");
    sendReq(32'h000C_0000, 1, 0, "R3 just above window");
    sendReq(32'h0100_0000, 0, 1, "R3 above 16MB");

    // R2 hole
    sendReq(32'h00F0_0000, 0, 0, "R2 hole disabled");
    cfgWrite(8'h48, 32'hFFFF_FFFF);
    cfgRead(8'h48, "R6 hole dword keeps only bit 7");
    sendReq(32'h00F0_0000, 0, 0, "R2 hole bottom");
    sendReq(32'h00FF_FFFF, 1, 1, "R2 hole top");
    sendReq(32'h00EF_FFFF, 0, 0, "R3 below hole");
    sendReq(32'h0100_0000, 0, 0, "R3 above hole");
    cfgWrite(8'h48, 32'h0);
    sendReq(32'h00F8_0000, 0, 0, "R2 hole cleared again");

    // R6 read-only field and unused offsets
    cfgWrite(8'h4C, 32'h0000_0500);
    cfgRead(8'h4C, "R6 base segment not writable");
    cfgRead(8'h50, "R6 unused offset reads zero");
    cfgWrite(8'h50, 32'hFFFF_FFFF);
    cfgRead(8'h48, "R6 stray write leaves hole dword");
    cfgRead(8'h4C, "R6 stray write leaves smram dword");

    // R7 window disabled, then R10 write timing
    sendReq(32'h000A_0000, 1, 0, "R7 window without enable");
    writeWithReq(8'h4C, B_GEN, 32'h000A_0000, 1, 0, "R10 same-cycle request sees old value");
    sendReq(32'h000A_0000, 1, 0, "R10 next-cycle request sees new value");
    sendReq(32'h000B_FFFF, 1, 1, "R7 window top in SMM");
    sendReq(32'h000A_0000, 0, 0, "R7 window outside SMM forwarded");
    sendReq(32'h0009_FFFF, 0, 0, "R3 just below window");

    // R8 closed
    cfgWrite(8'h4C, B_GEN | B_CLOSED);
    sendReq(32'h000A_4000, 1, 0, "R8 closed SMM data forwarded");
    sendReq(32'h000A_4000, 1, 1, "R8 closed SMM code to DRAM");

    // R9 open
    cfgWrite(8'h4C, B_OPEN);
    sendReq(32'h000B_0000, 0, 0, "R9 open outside SMM");
    sendReq(32'h000B_0000, 1, 0, "R9 open in SMM without enable");
    cfgWrite(8'h4C, B_OPEN | B_CLOSED);
    sendReq(32'h000B_0000, 1, 0, "R9 open and closed SMM data");
    sendReq(32'h000B_0000, 0, 0, "R9 open and closed outside SMM");
    sendReq(32'h000B_0000, 1, 1, "R9 open and closed SMM code");

    // R4 / R5 lock
    cfgWrite(8'h4C, B_OPEN | B_GEN);
    cfgWrite(8'h4C, B_OPEN | B_GEN | B_LOCK);
    cfgRead(8'h4C, "R5 lock clears open");
    sendReq(32'h000A_0000, 0, 0, "R5 locked window hidden outside SMM");
    cfgWrite(8'h4C, 32'h0);
    cfgRead(8'h4C, "R4 lock survives zero write");
    cfgWrite(8'h4C, B_OPEN | B_CLOSED);
    cfgRead(8'h4C, "R5 open ignored closed taken while locked");
    sendReq(32'h000A_0000, 1, 0, "R5 closed still acts after lock");
    sendReq(32'h000A_0000, 0, 1, "R5 open write ignored after lock");
    cfgWrite(8'h4C, 32'h0);
    sendReq(32'h000A_0000, 1, 0, "R5 enable frozen by lock");

    // R4 reset clears the lock
    rstN = 1'b0;
    modelReset();
    stepCycle();
    rstN = 1'b1;
    cfgRead(8'h4C, "R4 reset clears lock");
    cfgWrite(8'h4C, B_GEN);
    cfgRead(8'h4C, "R4 enable writable after reset");

    stepCycle();
    stepCycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule